// File: doc/BRIEF.md
# SDRAM Command Mode Issuer

This block is the command engine of an SDRAM controller that serves two chip-select banks. Software does not rely on a hardwired power-up machine. It steps the memory through its start-up sequence one command at a time. Each step is a single write of a command word. The word carries a 3-bit command code, a pair of bank-target bits, a repeat count for auto-refresh and a mode-register payload. The engine then drives the SDRAM control pins and raises `busy` until the command and its governing delay have finished. Software polls `busy` before writing the next word.

A typical bring-up runs in this order: enable the clock, wait at least 200 µs, precharge all rows, issue a burst of auto-refreshes, load the mode register, then enter normal mode. A separate timing word supplies the delays in clock cycles.

A built-in refresh timer takes over periodic refresh once normal mode is running. Each time it expires, it sends one auto-refresh to every bank whose mode register has been loaded. It never pre-empts a software command.

Top module: `sdram_cmd_issuer`

## Requirements
- R1: While reset is asserted, and until the first accepted command, `busy` is 0, `sdCke` is 0, both `sdCsN` bits are 1, `sdRasN`/`sdCasN`/`sdWeN` are 1 and `sdAddr` is 0.
- R2: The command code sits in `cmdWord[2:0]` and is decoded as follows: 0 normal, 1 clock on, 2 precharge-all, 3 auto-refresh, 4 mode load, 5 self-refresh, 6 power-down. Code 7 is ignored: `busy` stays low and the pins stay idle.
- R3: `cmdWord[4]` selects bank 1, which drives `sdCsN[0]`. `cmdWord[3]` selects bank 2, which drives `sdCsN[1]`. A pin command asserts every selected chip select low in the same single cycle, and no chip select goes low outside an issue cycle.
- R4: Precharge-all drives RAS low, CAS high, WE low and `sdAddr[10]` high for one cycle. It is followed by max(row-precharge, write-recovery)+1 busy cycles.
- R5: Auto-refresh takes its count N from `cmdWord[8:5]` and issues N+1 refresh commands (RAS low, CAS low, WE high). Each refresh is followed by row-cycle+1 busy cycles.
- R6: Mode load drives RAS, CAS and WE low and puts `cmdWord[21:9]` on `sdAddr`, with `sdBa` at 0. It is followed by load-to-active+1 busy cycles.
- R7: Codes 0 and 1 set `sdCke` high. Codes 5 and 6 clear it. The new level is visible from the cycle after the command is accepted.
- R8: Self-refresh issues a refresh command with `sdCke` already low, followed by self-refresh-time+1 busy cycles. The first code 0 or 1 after a self-refresh adds self-refresh-exit+1 busy cycles after its issue cycle.
- R9: `busy` rises in the cycle after a command is accepted. Any command written while `busy` is high is ignored. Codes 0, 1 and 6 keep `busy` high for exactly one cycle unless R8 adds an exit delay.
- R10: The timing word holds 4-bit delay fields, each meaning value+1 cycles: load-to-active at [3:0], self-refresh exit at [7:4], self-refresh time at [11:8], row cycle at [15:12], write recovery at [19:16] and row precharge at [23:20].
- R11: The refresh period P is `rfshWord[13:1]`, i.e. the register value shifted right by one. The timer runs only while the last accepted command was normal mode and P is non-zero. It expires every P+1 cycles, and each expiry sends one auto-refresh (with row-cycle+1 busy cycles) to every bank that has received a mode load.
- R12: A refresh that falls due while `busy` is high, or in the same cycle as an accepted software write, is held. It is then issued in the first idle cycle that has no software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmdWrEn | input | 1 | Command word write strobe |
| cmdWord | input | 22 | Command code, bank targets, refresh count, mode payload |
| timWrEn | input | 1 | Timing word write strobe |
| timWord | input | 24 | Six 4-bit delay fields |
| rfshWrEn | input | 1 | Refresh timer write strobe |
| rfshWord | input | 13 | Refresh register bits [13:1], the period value |
| busy | output | 1 | High while a command or its delay is in progress |
| sdCke | output | 1 | SDRAM clock enable |
| sdCsN | output | 2 | Chip selects, active low; [0] bank 1, [1] bank 2 |
| sdRasN | output | 1 | Row address strobe, active low |
| sdCasN | output | 1 | Column address strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdAddr | output | 13 | SDRAM address bus |
| sdBa | output | 2 | SDRAM bank address |

## Verification
The bench builds the block with its default parameters: a 13-bit address, 4-bit delay fields, a 4-bit refresh count and a 13-bit refresh period. With 4-bit fields the largest burst (sixteen refreshes) and delays from one to sixteen cycles can be covered in a short run. A 13-bit address makes both the payload boundary at bit 21 and the precharge address bit observable. A short refresh period, paired with normal-mode writes placed at every offset within one period, makes the timer collide with software writes and exercises the hold rule.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  typedef enum logic [2:0] {
    MODE_NORMAL = 3'd0,
    MODE_CKE_ON = 3'd1,
    MODE_PALL   = 3'd2,
    MODE_AREF   = 3'd3,
    MODE_LMR    = 3'd4,
    MODE_SELF   = 3'd5,
    MODE_PDOWN  = 3'd6,
    MODE_RSVD   = 3'd7
  } cmdMode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } engState_e;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic accept;     // software command taken this cycle
    logic autoStart;  // timer refresh started this cycle
    logic issue;      // command cycle on the pins
  } ctrlStb_t;

endpackage

// File: rtl/sdram_cmd_dp.sv
module sdram_cmd_dp
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int TF_W   = 4,
  parameter int RCNT_W = 4,
  parameter int RFSH_W = 13,
  parameter int BA_W   = 2,
  localparam int PAY_LSB = 5 + RCNT_W,
  localparam int CMD_W   = PAY_LSB + ADDR_W,
  localparam int NFLD    = 6,
  localparam int TIM_W   = NFLD * TF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic              timWrEn,
  input  logic [TIM_W-1:0]  timWord,
  input  logic              rfshWrEn,
  input  logic [RFSH_W:1]   rfshWord,
  input  ctrlStb_t          stb,
  output cmdMode_e          reqMode,
  output logic [RCNT_W-1:0] reqCount,
  output logic              refreshDue,
  output logic              issueWait,
  output logic [TF_W-1:0]   issueDelay,
  output logic              sdCke,
  output logic [1:0]        sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [ADDR_W-1:0] sdAddr,
  output logic [BA_W-1:0]   sdBa
);

  localparam int F_MRD  = 0;
  localparam int F_XSR  = 1;
  localparam int F_RAS  = 2;
  localparam int F_RC   = 3;
  localparam int F_WR   = 4;
  localparam int F_RP   = 5;
  localparam int AP_BIT = 10;

  logic [1:0] reqTgt;
  assign reqMode  = cmdMode_e'(cmdWord[2:0]);
  assign reqCount = cmdWord[5 +: RCNT_W];
  assign reqTgt   = {cmdWord[3], cmdWord[4]};

  // Latched command
  cmdMode_e          curMode;
  logic [1:0]        curTgt;
  logic [ADDR_W-1:0] curPay;
  logic              curXsr;

  // Device state
  logic       ckeReg, selfReg, normReg;
  logic [1:0] initMask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curMode  <= MODE_NORMAL;
      curTgt   <= '0;
      curPay   <= '0;
      curXsr   <= 1'b0;
      ckeReg   <= 1'b0;
      selfReg  <= 1'b0;
      normReg  <= 1'b0;
      initMask <= '0;
    end else if (stb.accept) begin
      curMode <= reqMode;
      curTgt  <= reqTgt;
      curPay  <= cmdWord[PAY_LSB +: ADDR_W];
      curXsr  <= selfReg && (reqMode == MODE_NORMAL || reqMode == MODE_CKE_ON);
      normReg <= (reqMode == MODE_NORMAL);
      case (reqMode)
        MODE_NORMAL, MODE_CKE_ON: begin ckeReg <= 1'b1; selfReg <= 1'b0; end
        MODE_SELF:                begin ckeReg <= 1'b0; selfReg <= 1'b1; end
        MODE_PDOWN:               ckeReg <= 1'b0;
        MODE_LMR:                 initMask <= initMask | reqTgt;
        default: ;
      endcase
    end else if (stb.autoStart) begin
      curMode <= MODE_AREF;
      curTgt  <= initMask;
      curPay  <= '0;
      curXsr  <= 1'b0;
    end
  end

  // Timing fields
  logic [TIM_W-1:0] timReg;
  logic [TF_W-1:0]  fld [NFLD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       timReg <= '0;
    else if (timWrEn) timReg <= timWord;
  end

  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    assign fld[g] = timReg[g*TF_W +: TF_W];
  end

  logic [TF_W-1:0] pallDelay;
  assign pallDelay = (fld[F_RP] > fld[F_WR]) ? fld[F_RP] : fld[F_WR];

  always_comb begin
    issueWait  = 1'b0;
    issueDelay = '0;
    case (curMode)
      MODE_PALL:   begin issueWait = 1'b1; issueDelay = pallDelay;  end
      MODE_AREF:   begin issueWait = 1'b1; issueDelay = fld[F_RC];  end
      MODE_LMR:    begin issueWait = 1'b1; issueDelay = fld[F_MRD]; end
      MODE_SELF:   begin issueWait = 1'b1; issueDelay = fld[F_RAS]; end
      MODE_NORMAL,
      MODE_CKE_ON: begin issueWait = curXsr; issueDelay = fld[F_XSR]; end
      default: ;
    endcase
  end

  // Refresh timer
  logic [RFSH_W-1:0] rfshPer, rfshCnt;
  logic              running, expire, duePend;

  assign running = normReg && (rfshPer != '0);
  assign expire  = running && (rfshCnt == '0) && !rfshWrEn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rfshPer <= '0;
      rfshCnt <= '0;
      duePend <= 1'b0;
    end else begin
      if (rfshWrEn) begin
        rfshPer <= rfshWord;
        rfshCnt <= rfshWord;
      end else if (running) begin
        if (rfshCnt == '0) rfshCnt <= rfshPer;
        else               rfshCnt <= rfshCnt - 1'b1;
      end
      duePend <= (duePend && !stb.autoStart) || (expire && (initMask != '0));
    end
  end

  assign refreshDue = duePend;

  // Pin decode
  logic pinCmd;
  assign pinCmd = stb.issue && (curMode == MODE_PALL || curMode == MODE_AREF ||
                                curMode == MODE_LMR  || curMode == MODE_SELF);

  assign sdCke  = ckeReg;
  assign sdCsN  = pinCmd ? ~curTgt : 2'b11;
  assign sdRasN = !pinCmd;
  assign sdCasN = !(pinCmd && curMode != MODE_PALL);
  assign sdWeN  = !(pinCmd && (curMode == MODE_PALL || curMode == MODE_LMR));
  assign sdBa   = '0;

  always_comb begin
    sdAddr = '0;
    if (pinCmd && curMode == MODE_PALL) sdAddr[AP_BIT] = 1'b1;
    else if (pinCmd && curMode == MODE_LMR) sdAddr = curPay;
  end

  // R3: a chip select is low only in an issue cycle
  a_r3_cs_only_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (sdCsN != 2'b11) |-> stb.issue);

  // R7: entering self-refresh or power-down lowers the clock enable
  a_r7_cke_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.accept && (reqMode == MODE_SELF || reqMode == MODE_PDOWN)) |=> !sdCke);

  // R11: a timed refresh is only requested once a bank is initialised
  a_r11_due_needs_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refreshDue) |-> (initMask != '0));

endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
#(
  parameter int TF_W   = 4,
  parameter int RCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdWrEn,
  input  cmdMode_e          reqMode,
  input  logic [RCNT_W-1:0] reqCount,
  input  logic              refreshDue,
  input  logic              issueWait,
  input  logic [TF_W-1:0]   issueDelay,
  output ctrlStb_t          stb,
  output logic              busy
);

  engState_e         state;
  logic [TF_W-1:0]   waitCnt;
  logic [RCNT_W-1:0] rptCnt;
  logic              accept, autoStart;

  assign accept    = (state == ST_IDLE) && cmdWrEn && (reqMode != MODE_RSVD);
  assign autoStart = (state == ST_IDLE) && !accept && refreshDue;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      rptCnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state  <= ST_ISSUE;
            rptCnt <= (reqMode == MODE_AREF) ? reqCount : '0;
          end else if (autoStart) begin
            state  <= ST_ISSUE;
            rptCnt <= '0;
          end
        end
        ST_ISSUE: begin
          if (issueWait) begin
            state   <= ST_WAIT;
            waitCnt <= issueDelay;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (waitCnt == '0) begin
            if (rptCnt != '0) begin
              state  <= ST_ISSUE;
              rptCnt <= rptCnt - 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            waitCnt <= waitCnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state != ST_IDLE);
  assign stb.accept    = accept;
  assign stb.autoStart = autoStart;
  assign stb.issue     = (state == ST_ISSUE);

  // R9: an accepted command makes busy visible on the next cycle
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    stb.accept |=> busy);

  // R2: the reserved code leaves the engine idle
  a_r2_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && cmdWrEn && reqMode == MODE_RSVD && !refreshDue) |=> !busy);

  // R12: a due refresh is held while the engine is busy
  a_r12_due_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && refreshDue) |=> refreshDue);

endmodule

// File: rtl/sdram_cmd_issuer.sv
module sdram_cmd_issuer
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int TF_W   = 4,
  parameter int RCNT_W = 4,
  parameter int RFSH_W = 13,
  parameter int BA_W   = 2,
  localparam int CMD_W = 5 + RCNT_W + ADDR_W,
  localparam int TIM_W = 6 * TF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdWrEn,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic              timWrEn,
  input  logic [TIM_W-1:0]  timWord,
  input  logic              rfshWrEn,
  input  logic [RFSH_W:1]   rfshWord,
  output logic              busy,
  output logic              sdCke,
  output logic [1:0]        sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [ADDR_W-1:0] sdAddr,
  output logic [BA_W-1:0]   sdBa
);

  ctrlStb_t          stb;
  cmdMode_e          reqMode;
  logic [RCNT_W-1:0] reqCount;
  logic              refreshDue, issueWait;
  logic [TF_W-1:0]   issueDelay;

  sdram_cmd_ctrl #(.TF_W(TF_W), .RCNT_W(RCNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdWrEn(cmdWrEn), .reqMode(reqMode),
    .reqCount(reqCount), .refreshDue(refreshDue), .issueWait(issueWait),
    .issueDelay(issueDelay), .stb(stb), .busy(busy)
  );

  sdram_cmd_dp #(.ADDR_W(ADDR_W), .TF_W(TF_W), .RCNT_W(RCNT_W),
                 .RFSH_W(RFSH_W), .BA_W(BA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .cmdWord(cmdWord), .timWrEn(timWrEn),
    .timWord(timWord), .rfshWrEn(rfshWrEn), .rfshWord(rfshWord), .stb(stb),
    .reqMode(reqMode), .reqCount(reqCount), .refreshDue(refreshDue),
    .issueWait(issueWait), .issueDelay(issueDelay), .sdCke(sdCke),
    .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdAddr(sdAddr), .sdBa(sdBa)
  );

endmodule

// File: tb/sdram_cmd_issuer_bench.sv
module sdram_cmd_issuer_bench;

  localparam int ADDR_W = 13;
  localparam int TF_W   = 4;
  localparam int RCNT_W = 4;
  localparam int RFSH_W = 13;
  localparam int CMD_W  = 5 + RCNT_W + ADDR_W;
  localparam int TIM_W  = 6 * TF_W;

  logic clk = 1'b0;
  logic rst_n;
  logic cmdWrEn, timWrEn, rfshWrEn;
  logic [CMD_W-1:0]  cmdWord;
  logic [TIM_W-1:0]  timWord;
  logic [RFSH_W:1]   rfshWord;
  logic busy, sdCke, sdRasN, sdCasN, sdWeN;
  logic [1:0] sdCsN, sdBa;
  logic [ADDR_W-1:0] sdAddr;

  always #5 clk = ~clk;

  sdram_cmd_issuer u_sdram_cmd_issuer (
    .clk(clk), .rst_n(rst_n), .cmdWrEn(cmdWrEn), .cmdWord(cmdWord),
    .timWrEn(timWrEn), .timWord(timWord), .rfshWrEn(rfshWrEn),
    .rfshWord(rfshWord), .busy(busy), .sdCke(sdCke), .sdCsN(sdCsN),
    .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN), .sdAddr(sdAddr),
    .sdBa(sdBa)
  );

  typedef struct packed {
    logic              busy;
    logic [1:0]        csN;
    logic [2:0]        rcw;
    logic [ADDR_W-1:0] addr;
  } exp_t;

  localparam exp_t IDLE_E = '{busy: 1'b0, csN: 2'b11, rcw: 3'b111, addr: '0};
  localparam exp_t NOPB_E = '{busy: 1'b1, csN: 2'b11, rcw: 3'b111, addr: '0};

  exp_t expQ[$];
  exp_t curExp;
  int   checks = 0;
  int   errors = 0;
  string tag = "R1";

  // Reference model state
  bit       ckeM, selfM, normM, pendM;
  bit [1:0] initM;
  int       perM, tmrM;
  int       tMrd, tXsr, tRas, tRc, tWr, tRp;

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("busy", busy, curExp.busy);
    chk("cke", sdCke, ckeM);
    chk("csN", sdCsN, curExp.csN);
    chk("ras/cas/we", {sdRasN, sdCasN, sdWeN}, curExp.rcw);
    chk("addr", sdAddr, curExp.addr);
    chk("ba", sdBa, 0);
  endtask

  task automatic pushCmd(bit [1:0] tgt, bit [2:0] rcw, int addr);
    exp_t e;
    e.busy = 1'b1; e.csN = ~tgt; e.rcw = rcw; e.addr = ADDR_W'(addr);
    expQ.push_back(e);
  endtask

  task automatic pushWait(int n);
    for (int k = 0; k <= n; k++) expQ.push_back(NOPB_E);
  endtask

  task automatic modelEdge(bit wr, logic [CMD_W-1:0] w, bit tw,
                           logic [TIM_W-1:0] tv, bit rw, logic [RFSH_W:1] rv);
    bit       accept, run, oldPend;
    bit [1:0] oldInit, tgt;
    int       m;
    m       = int'(w[2:0]);
    tgt     = {w[3], w[4]};
    accept  = wr && (m != 7) && !curExp.busy;
    run     = normM && (perM != 0);
    oldPend = pendM;
    oldInit = initM;
    if (tw) begin
      tMrd = int'(tv[3:0]);   tXsr = int'(tv[7:4]);   tRas = int'(tv[11:8]);
      tRc  = int'(tv[15:12]); tWr  = int'(tv[19:16]); tRp  = int'(tv[23:20]);
    end
    if (accept) begin
      case (m)
        0, 1: begin
          expQ.push_back(NOPB_E);
          if (selfM) pushWait(tXsr);
          ckeM = 1; selfM = 0;
        end
        2: begin pushCmd(tgt, 3'b010, 1 << 10); pushWait(tRp > tWr ? tRp : tWr); end
        3: for (int k = 0; k <= int'(w[8:5]); k++) begin
             pushCmd(tgt, 3'b001, 0); pushWait(tRc);
           end
        4: begin
          pushCmd(tgt, 3'b000, int'(w[CMD_W-1:9])); pushWait(tMrd);
          initM = initM | tgt;
        end
        5: begin pushCmd(tgt, 3'b001, 0); pushWait(tRas); ckeM = 0; selfM = 1; end
        default: begin expQ.push_back(NOPB_E); ckeM = 0; end
      endcase
      normM = (m == 0);
    end else if (!curExp.busy && oldPend) begin
      pushCmd(oldInit, 3'b001, 0); pushWait(tRc);
      pendM = 0;
    end
    if (rw) begin
      perM = int'(rv); tmrM = perM;
    end else if (run) begin
      if (tmrM == 0) begin
        tmrM = perM;
        if (oldInit != 0) pendM = 1;
      end else tmrM--;
    end
    curExp = (expQ.size() != 0) ? expQ.pop_front() : IDLE_E;
  endtask

  task automatic tick(bit wr, logic [CMD_W-1:0] w, bit tw, logic [TIM_W-1:0] tv,
                      bit rw, logic [RFSH_W:1] rv);
    cmdWrEn = wr; cmdWord = w; timWrEn = tw; timWord = tv;
    rfshWrEn = rw; rfshWord = rv;
    modelEdge(wr, w, tw, tv, rw, rv);
    @(negedge clk);
    compareAll();
    cmdWrEn = 0; timWrEn = 0; rfshWrEn = 0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick(0, '0, 0, '0, 0, '0);
  endtask

  task automatic issue(logic [CMD_W-1:0] w);
    while (curExp.busy) idle(1);
    tick(1, w, 0, '0, 0, '0);
  endtask

  task automatic drain();
    while (curExp.busy) idle(1);
  endtask

  function automatic logic [CMD_W-1:0] cw(int mode, bit b1, bit b2, int cnt, int pay);
    return {ADDR_W'(pay), RCNT_W'(cnt), b1, b2, 3'(mode)};
  endfunction

  function automatic logic [TIM_W-1:0] tword(int mrd, int xsr, int ras, int rc,
                                             int wr, int rp);
    return {4'(rp), 4'(wr), 4'(rc), 4'(ras), 4'(xsr), 4'(mrd)};
  endfunction

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired (%s)", tag);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; cmdWrEn = 0; timWrEn = 0; rfshWrEn = 0;
    cmdWord = '0; timWord = '0; rfshWord = '0;
    curExp = IDLE_E;
    repeat (3) @(negedge clk);
    tag = "R1";
    compareAll();
    rst_n = 1;
    idle(3);

    tag = "R10";
    tick(0, '0, 1, tword(2, 3, 4, 5, 6, 1), 0, '0);
    idle(2);

    tag = "R7";
    issue(cw(1, 1, 1, 0, 0));
    idle(20);

    tag = "R4";
    issue(cw(2, 1, 1, 0, 0));
    tag = "R9";
    tick(1, cw(3, 1, 1, 2, 0), 0, '0, 0, '0);
    drain();

    tag = "R5";
    issue(cw(3, 1, 1, 7, 0));
    tag = "R3";
    issue(cw(3, 1, 0, 0, 0));
    issue(cw(2, 0, 1, 0, 0));
    issue(cw(2, 0, 0, 0, 0));

    tag = "R6";
    issue(cw(4, 1, 0, 0, 'h20));
    issue(cw(4, 0, 1, 0, 'h1fff));
    drain();

    tag = "R2";
    tick(1, cw(7, 1, 1, 3, 'h55), 0, '0, 0, '0);
    idle(3);

    tag = "R9";
    issue(cw(0, 1, 1, 0, 0));
    idle(2);

    tag = "R11";
    tick(0, '0, 0, '0, 1, RFSH_W'(12));
    idle(60);

    tag = "R12";
    for (int off = 0; off < 15; off++) begin
      idle(off);
      issue(cw(0, 1, 1, 0, 0));
    end
    issue(cw(3, 1, 1, 3, 0));
    issue(cw(0, 1, 1, 0, 0));
    idle(40);

    tag = "R8";
    issue(cw(5, 1, 1, 0, 0));
    idle(6);
    issue(cw(0, 1, 1, 0, 0));
    drain();
    tag = "R7";
    issue(cw(6, 1, 1, 0, 0));
    idle(4);
    issue(cw(1, 1, 1, 0, 0));
    drain();

    tag = "R5";
    tick(0, '0, 1, tword(15, 0, 0, 0, 9, 2), 0, '0);
    issue(cw(3, 1, 1, 15, 0));
    tag = "R4";
    issue(cw(2, 1, 1, 0, 0));
    tag = "R6";
    issue(cw(4, 1, 1, 0, 'h1234));
    drain();
    idle(5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule